// File: doc/BRIEF.md
# MMU Fault Recorder with Pseudo-Random Refill Set

This block captures the details of every address-translation fault into two registers that software reads from its fault handler. A one-cycle fault strobe comes with a flag that says whether the lookup missed, the set that matched when it did not miss, the virtual page number, the process identifier and the access type. On the clock edge that samples the strobe, the block records these values.

For a miss, the refill handler needs a victim set. The block takes that set from a 16-bit linear feedback shift register, which advances once on every fault of either kind. For a protection fault, the block reports the set that matched. The translation storage and the permission checks are outside this block.

Top module: `mmu_fault_log`

## Requirements
- R1: After reset the shift register holds 0xCCCC, and both the select output and the cause output read 0.
- R2: On each advance, the shift register moves right by one bit. Bit 15 takes the parity of the register ANDed with the tap mask 0x8805, which selects taps 15, 11, 2 and 0.
- R3: The shift register advances once on every fault strobe, whether the fault is a miss or a protection fault.
- R4: On a miss, the reported set is bits [1:0] of the shift register as they were before that fault's advance.
- R5: On a protection fault (miss flag low), the reported set is the matched-set input.
- R6: On a fault, the select register is first cleared. Bits [3:0] then take the low 4 bits of the virtual page number, and bits [5:4] take the reported set. Bits [31:6] read 0.
- R7: On a fault, the cause register takes the PID in bits [7:0], the 2-bit access code in bits [9:8] and the 19-bit virtual page number in bits [31:13].
- R8: A fault leaves cause bits [12:10] at their previous value.
- R9: Without a fault strobe, no register changes. The values recorded on a strobe can be read in the cycle after it.
- R10: The access code is 0 for read, 1 for write and 2 for execute. It is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_i | input | 1 | One-cycle fault strobe |
| miss_i | input | 1 | 1 = lookup miss, 0 = protection fault |
| hit_set_i | input | 2 | Set that matched, used when miss_i is 0 |
| vpn_i | input | 19 | Virtual page number of the faulting access |
| pid_i | input | 8 | Current process identifier |
| acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute |
| sel_o | output | 32 | Select register (index and set) |
| cause_o | output | 32 | Cause register (PID, access code, page number) |

## Verification
The assertions check on every cycle that:
- the registers hold still when there is no strobe;
- the shift register moves right on each fault;
- the index and the set, whether taken from the shift register or from the matched set, land in the select register;
- the page number lands in the cause register and the unused cause bits are kept.

Only the bench scenarios can show three things: the exact seed and feedback taps, seen through the sequence of victim sets over many misses; the reset values; and the fact that protection faults still consume a step of the random sequence.

// File: rtl/mmu_fault_log.sv
module mmu_fault_log #(
  parameter logic [15:0] SEED = 16'hCCCC,
  parameter logic [15:0] TAPS = 16'h8805
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fault_i,
  input  logic        miss_i,
  input  logic [1:0]  hit_set_i,
  input  logic [18:0] vpn_i,
  input  logic [7:0]  pid_i,
  input  logic [1:0]  acc_i,
  output logic [31:0] sel_o,
  output logic [31:0] cause_o
);

  logic [15:0] lfsr_q;
  logic [31:0] sel_q, cause_q;
  logic        fb;
  logic [1:0]  set_w;

  assign fb    = ^(lfsr_q & TAPS);
  assign set_w = miss_i ? lfsr_q[1:0] : hit_set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= SEED;
      sel_q   <= '0;
      cause_q <= '0;
    end else if (fault_i) begin
      lfsr_q  <= {fb, lfsr_q[15:1]};
      sel_q   <= {26'd0, set_w, vpn_i[3:0]};
      cause_q <= {vpn_i, cause_q[12:10], acc_i, pid_i};
    end
  end

  assign sel_o   = sel_q;
  assign cause_o = cause_q;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> $stable(lfsr_q) && $stable(sel_q) && $stable(cause_q));
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> lfsr_q[14:0] == $past(lfsr_q[15:1]));
  a_r4_miss_set: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i && miss_i |=> sel_o[5:4] == $past(lfsr_q[1:0]));
  a_r5_hit_set: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i && !miss_i |=> sel_o[5:4] == $past(hit_set_i));
  a_r6_index: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> sel_o[3:0] == $past(vpn_i[3:0]));
  a_r7_vpn: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> cause_o[31:13] == $past(vpn_i));
  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> cause_o[12:10] == $past(cause_o[12:10]));

endmodule

// File: tb/test_mmu_fault_log.sv
module test_mmu_fault_log;
  logic clk = 0, rst_n = 0;
  logic fault_i = 0, miss_i = 0;
  logic [1:0] hit_set_i = 0, acc_i = 0;
  logic [18:0] vpn_i = 0;
  logic [7:0] pid_i = 0;
  logic [31:0] sel_o, cause_o;

  int checks = 0, fails = 0;
  logic [15:0] m_lfsr;
  logic [31:0] m_cause;
  bit done = 0;

  always #10 clk = ~clk;

  mmu_fault_log i_mmu_fault_log (.*);

  // Vector layout: [31] miss, [30:29] matched set, [28:10] vpn, [9:2] pid, [1:0] access
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 2'd3, 19'h12345, 8'hA5, 2'd0},
    {1'b1, 2'd0, 19'h7FFFF, 8'h01, 2'd1},
    {1'b0, 2'd3, 19'h0000A, 8'hFF, 2'd1},
    {1'b1, 2'd1, 19'h40001, 8'h3C, 2'd2},
    {1'b0, 2'd1, 19'h2222F, 8'h00, 2'd2},
    {1'b1, 2'd2, 19'h00000, 8'h80, 2'd0},
    {1'b0, 2'd2, 19'h5A5A5, 8'h5A, 2'd0},
    {1'b1, 2'd0, 19'h1F00E, 8'h7E, 2'd3},
    {1'b1, 2'd0, 19'h33333, 8'h11, 2'd1},
    {1'b1, 2'd0, 19'h6AAA7, 8'h22, 2'd2}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] v);
    logic [1:0] set_e;
    @(negedge clk);
    fault_i = 1; miss_i = v[31]; hit_set_i = v[30:29];
    vpn_i = v[28:10]; pid_i = v[9:2]; acc_i = v[1:0];
    set_e = v[31] ? m_lfsr[1:0] : v[30:29];
    m_lfsr = {^(m_lfsr & 16'h8805), m_lfsr[15:1]};
    m_cause = {v[28:10], m_cause[12:10], v[1:0], v[9:2]};
    @(negedge clk);
    fault_i = 0;
    chk("R4/R5/R6 sel", sel_o, {26'd0, set_e, v[13:10]});
    chk("R7/R8/R10 cause", cause_o, m_cause);
  endtask

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_lfsr = 16'hCCCC;
    m_cause = 0;
    repeat (3) @(negedge clk);
    chk("R1 sel reset", sel_o, 32'd0);
    chk("R1 cause reset", cause_o, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3: table walk; the misses expose the LFSR sequence and the hits still advance it
    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R9: inputs change without a strobe, so nothing may change
    @(negedge clk);
    miss_i = 1; vpn_i = 19'h7ABCD; pid_i = 8'h99; acc_i = 2'd2; hit_set_i = 2'd3;
    repeat (4) @(negedge clk);
    chk("R9 sel hold", sel_o, {26'd0, sel_o[5:4], VEC[NV-1][13:10]});
    chk("R9 cause hold", cause_o, m_cause);

    // R1 R3: a long run of misses checks the victim-set sequence from seed 0xCCCC
    for (int i = 0; i < 40; i++)
      apply({1'b1, 2'd0, 19'(i * 977), 8'(i), 2'(i % 3)});

    // R5: a protection fault right after a miss reports the matched set
    apply({1'b0, 2'd2, 19'h00011, 8'h44, 2'd1});
    apply({1'b1, 2'd0, 19'h00012, 8'h45, 2'd0});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule